// File: doc/BRIEF.md
# I2C Target Register File

This block is an I2C target that answers at the fixed 7-bit bus address 0x30 and exposes a small map of 8-bit registers. It runs entirely on the system clock. SCL and SDA are oversampled through two-flop synchronizers, and START, STOP and clock edges are found by edge detection. SDA is open-drain: the block reports it through `sda_i` and pulls it low by raising `sda_oe_o`. Clock stretching and general-call addressing are not provided.

A write transaction carries the register index in its first byte after the address. Every later byte in that transaction is data for the current index. A read transaction returns bytes starting at the current index, so an index set by a write followed by a repeated START gives a random read. The index advances after every data byte moved in either direction. Only the user LED register can be written, and its value drives `user_led_o`. The other registers return a boot mode variant constant, two revision constants and a live snapshot of `status_i`. None of the pins is a data stream: the bus pins follow I2C timing and the status and LED pins are plain levels, so the block has no valid/ready handshake and applies no back-pressure.

Top module: `i2c_regfile_target`

## Requirements
- R1: After reset, `user_led_o` equals 0x01 and `sda_oe_o` is low.
- R2: An address byte whose upper seven bits are 0x30 is acknowledged, for both R/W values (bit 0 of the byte: 0 = write, 1 = read). Acknowledgement means SDA is pulled low during the ninth clock.
- R3: An address byte with any other value is not acknowledged. SDA stays released for the rest of that transaction, until the next START.
- R4: In a write, the first byte after the address sets the register index and each further byte is data for it. The index increments by one after every data byte that is read or written, so consecutive bytes reach consecutive indices.
- R5: Index 0x00 is the user LED register. A byte written there appears on `user_led_o` and is returned when index 0x00 is read.
- R6: Reading index 0x01 returns the boot mode variant 0x01. Reading index 0x02 returns the logic revision 0x03, and reading index 0x03 returns the board revision 0x03.
- R7: Reading index 0x04 returns `status_i` as sampled when the byte starts to shift out. Bit 4 of that byte carries the RTC interrupt.
- R8: Writes to indices other than 0x00 are acknowledged and discarded. `user_led_o` and the read-back values do not change.
- R9: Reading any index from 0x05 to 0xFF returns 0x00.
- R10: After the master answers a read byte with NACK, the block releases SDA and sends no more data.
- R11: A START or STOP seen at any point, including inside a byte, restarts the byte engine. The next transaction is then handled normally.
- R12: `sda_oe_o` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe_o | output | 1 | Pull SDA low when 1, release when 0 |
| status_i | input | 8 | Live status inputs; bit 4 is the RTC interrupt |
| user_led_o | output | 8 | Contents of the user LED register |

## Verification
Both bus lines pass through two synchronizer flops and an edge register before the engine sees them. The engine then registers its reaction, so `sda_oe_o` answers an SCL falling edge on the third clock edge after the pin changes, and a written LED byte reaches `user_led_o` one cycle after that. The bench's master holds every bus phase for eight system clocks, which is longer than this latency. It samples SDA late in the SCL high phase and checks LED and read values only after the STOP, so every check falls after its result is due. A monitor sampling on the falling system-clock edge flags any change of `sda_oe_o` that happens while SCL is high.

// File: rtl/i2cr_pkg.sv
package i2cr_pkg;
  localparam int BYTE_W = 8;
  localparam int IDX_W  = 8;
  localparam int CNT_W  = 4;

  localparam logic [IDX_W-1:0] IDX_LED  = 8'h00;
  localparam logic [IDX_W-1:0] IDX_BOOT = 8'h01;
  localparam logic [IDX_W-1:0] IDX_CREV = 8'h02;
  localparam logic [IDX_W-1:0] IDX_PREV = 8'h03;
  localparam logic [IDX_W-1:0] IDX_STAT = 8'h04;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK
  } eng_state_t;
endpackage

// File: rtl/i2cr_sync.sv
module i2cr_sync #(
  parameter int LINES  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] din,
  output logic [LINES-1:0] level,
  output logic [LINES-1:0] rise,
  output logic [LINES-1:0] fall
);
  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] chain;
    logic              prev;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain <= '1;
        prev  <= 1'b1;
      end else begin
        chain <= {chain[STAGES-2:0], din[g]};
        prev  <= chain[STAGES-1];
      end
    end

    assign level[g] = chain[STAGES-1];
    assign rise[g]  = chain[STAGES-1] & ~prev;
    assign fall[g]  = ~chain[STAGES-1] & prev;
  end
endmodule

// File: rtl/i2cr_engine.sv
module i2cr_engine
  import i2cr_pkg::*;
#(
  parameter logic [6:0] TARGET_ADDR = 7'h30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_lvl,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda_lvl,
  input  logic              sda_rise,
  input  logic              sda_fall,
  input  logic [BYTE_W-1:0] rd_data,
  output logic [IDX_W-1:0]  idx,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [BYTE_W-1:0] wr_data,
  output logic              sda_oe,
  output logic              eng_idle,
  output logic              start_det,
  output logic              stop_det
);
  eng_state_t        st;
  logic [BYTE_W-1:0] sh;
  logic [CNT_W-1:0]  cnt;
  logic              rnw;
  logic              first;
  logic              mack;

  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

  // bus conditions: SDA moving while SCL stays high
  assign start_det = sda_fall & scl_lvl;
  assign stop_det  = sda_rise & scl_lvl;
  assign eng_idle  = (st == ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      sh      <= '0;
      cnt     <= '0;
      rnw     <= 1'b0;
      first   <= 1'b1;
      mack    <= 1'b0;
      idx     <= '0;
      wr_en   <= 1'b0;
      wr_idx  <= '0;
      wr_data <= '0;
      sda_oe  <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      if (start_det) begin
        st     <= ST_ADDR;
        cnt    <= '0;
        first  <= 1'b1;
        sda_oe <= 1'b0;
      end else if (stop_det) begin
        st     <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        unique case (st)
          ST_ADDR: begin
            if (scl_rise) begin
              sh  <= {sh[BYTE_W-2:0], sda_lvl};
              cnt <= cnt + 1'b1;
            end else if (scl_fall && cnt == LAST_BIT) begin
              if (sh[BYTE_W-1:1] == TARGET_ADDR) begin
                st     <= ST_ADDR_ACK;
                sda_oe <= 1'b1;
                rnw    <= sh[0];
              end else begin
                st <= ST_IDLE;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall) begin
              if (rnw) begin
                sh     <= rd_data;
                sda_oe <= ~rd_data[BYTE_W-1];
                cnt    <= CNT_W'(1);
                st     <= ST_RD;
              end else begin
                sda_oe <= 1'b0;
                cnt    <= '0;
                first  <= 1'b1;
                st     <= ST_WR;
              end
            end
          end
          ST_WR: begin
            if (scl_rise) begin
              sh  <= {sh[BYTE_W-2:0], sda_lvl};
              cnt <= cnt + 1'b1;
            end else if (scl_fall && cnt == LAST_BIT) begin
              sda_oe <= 1'b1;
              st     <= ST_WR_ACK;
              if (first) begin
                idx   <= sh;
                first <= 1'b0;
              end else begin
                wr_en   <= 1'b1;
                wr_idx  <= idx;
                wr_data <= sh;
                idx     <= idx + 1'b1;
              end
            end
          end
          ST_WR_ACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              cnt    <= '0;
              st     <= ST_WR;
            end
          end
          ST_RD: begin
            if (scl_fall) begin
              if (cnt == LAST_BIT) begin
                sda_oe <= 1'b0;
                st     <= ST_RD_ACK;
                idx    <= idx + 1'b1;
              end else begin
                sda_oe <= ~sh[BYTE_W-2];
                sh     <= {sh[BYTE_W-2:0], 1'b0};
                cnt    <= cnt + 1'b1;
              end
            end
          end
          ST_RD_ACK: begin
            if (scl_rise) begin
              mack <= ~sda_lvl;
            end else if (scl_fall) begin
              if (mack) begin
                sh     <= rd_data;
                sda_oe <= ~rd_data[BYTE_W-1];
                cnt    <= CNT_W'(1);
                st     <= ST_RD;
              end else begin
                st <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2cr_regmap.sv
module i2cr_regmap
  import i2cr_pkg::*;
#(
  parameter logic [BYTE_W-1:0] LED_INIT     = 8'h01,
  parameter logic [BYTE_W-1:0] BOOT_VARIANT = 8'h01,
  parameter logic [BYTE_W-1:0] LOGIC_REV    = 8'h03,
  parameter logic [BYTE_W-1:0] BOARD_REV    = 8'h03
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic [BYTE_W-1:0] status_i,
  output logic [BYTE_W-1:0] rd_data,
  output logic [BYTE_W-1:0] led_q
);
  // only the LED byte has storage; every other index is read-only
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      led_q <= LED_INIT;
    end else if (wr_en && wr_idx == IDX_LED) begin
      led_q <= wr_data;
    end
  end

  always_comb begin
    unique case (rd_idx)
      IDX_LED:  rd_data = led_q;
      IDX_BOOT: rd_data = BOOT_VARIANT;
      IDX_CREV: rd_data = LOGIC_REV;
      IDX_PREV: rd_data = BOARD_REV;
      IDX_STAT: rd_data = status_i;
      default:  rd_data = '0;
    endcase
  end
endmodule

// File: rtl/i2c_regfile_target.sv
module i2c_regfile_target
  import i2cr_pkg::*;
#(
  parameter logic [6:0]        TARGET_ADDR  = 7'h30,
  parameter int                SYNC_STAGES  = 2,
  parameter logic [BYTE_W-1:0] LED_INIT     = 8'h01,
  parameter logic [BYTE_W-1:0] BOOT_VARIANT = 8'h01,
  parameter logic [BYTE_W-1:0] LOGIC_REV    = 8'h03,
  parameter logic [BYTE_W-1:0] BOARD_REV    = 8'h03
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic [BYTE_W-1:0] status_i,
  output logic [BYTE_W-1:0] user_led_o
);
  localparam int SCL_L = 0;
  localparam int SDA_L = 1;

  logic [1:0]        lvl, rise, fall;
  logic              scl_fall;
  logic [IDX_W-1:0]  cur_idx;
  logic              wr_en;
  logic [IDX_W-1:0]  wr_idx;
  logic [BYTE_W-1:0] wr_data;
  logic [BYTE_W-1:0] rd_data;
  logic              eng_idle;
  logic              start_det;
  logic              stop_det;

  i2cr_sync #(.LINES(2), .STAGES(SYNC_STAGES)) sync_i (
    .clk   (clk),
    .rst_n (rst_n),
    .din   ({sda_i, scl_i}),
    .level (lvl),
    .rise  (rise),
    .fall  (fall)
  );

  assign scl_fall = fall[SCL_L];

  i2cr_engine #(.TARGET_ADDR(TARGET_ADDR)) eng_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_lvl   (lvl[SCL_L]),
    .scl_rise  (rise[SCL_L]),
    .scl_fall  (scl_fall),
    .sda_lvl   (lvl[SDA_L]),
    .sda_rise  (rise[SDA_L]),
    .sda_fall  (fall[SDA_L]),
    .rd_data   (rd_data),
    .idx       (cur_idx),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_data   (wr_data),
    .sda_oe    (sda_oe_o),
    .eng_idle  (eng_idle),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  i2cr_regmap #(
    .LED_INIT     (LED_INIT),
    .BOOT_VARIANT (BOOT_VARIANT),
    .LOGIC_REV    (LOGIC_REV),
    .BOARD_REV    (BOARD_REV)
  ) map_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_data  (wr_data),
    .rd_idx   (cur_idx),
    .status_i (status_i),
    .rd_data  (rd_data),
    .led_q    (user_led_o)
  );
endmodule

// File: rtl/i2cr_checker.sv
module i2cr_checker
  import i2cr_pkg::*;
#(
  parameter logic [BYTE_W-1:0] LED_INIT = 8'h01
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_i,
  input logic              sda_oe_o,
  input logic [BYTE_W-1:0] user_led_o,
  input logic              eng_idle,
  input logic              stop_det,
  input logic              scl_fall,
  input logic [IDX_W-1:0]  cur_idx,
  input logic              wr_en,
  input logic [IDX_W-1:0]  wr_idx
);
  p_reset_state_r1: assert property (@(posedge clk)
    !rst_n |=> (user_led_o == LED_INIT && !sda_oe_o));

  p_idle_released_r3: assert property (@(posedge clk) disable iff (!rst_n)
    eng_idle |-> !sda_oe_o);

  p_idx_on_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cur_idx) |-> $past(scl_fall));

  p_led_write_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(user_led_o) |-> $past(wr_en && wr_idx == IDX_LED));

  p_stop_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(stop_det) |-> !sda_oe_o);

  p_oe_scl_low_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe_o) |-> !scl_i);
endmodule

bind i2c_regfile_target i2cr_checker chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .scl_i      (scl_i),
  .sda_oe_o   (sda_oe_o),
  .user_led_o (user_led_o),
  .eng_idle   (eng_idle),
  .stop_det   (stop_det),
  .scl_fall   (scl_fall),
  .cur_idx    (cur_idx),
  .wr_en      (wr_en),
  .wr_idx     (wr_idx)
);

// File: tb/i2c_regfile_target_tb.sv
module i2c_regfile_target_tb_top;
  localparam int         Q   = 8;
  localparam logic [6:0] TGT = 7'h30;
  localparam int         NV  = 12;
  localparam int         WD  = 190000;

  // {is_write, index, write data, expected LED after write / expected read byte}
  localparam logic [24:0] VEC [NV] = '{
    {1'b0, 8'h00, 8'h00, 8'h01},
    {1'b1, 8'h00, 8'h5A, 8'h5A},
    {1'b0, 8'h00, 8'h00, 8'h5A},
    {1'b0, 8'h01, 8'h00, 8'h01},
    {1'b0, 8'h02, 8'h00, 8'h03},
    {1'b0, 8'h03, 8'h00, 8'h03},
    {1'b0, 8'h04, 8'h00, 8'h5C},
    {1'b0, 8'h05, 8'h00, 8'h00},
    {1'b0, 8'hFF, 8'h00, 8'h00},
    {1'b1, 8'h02, 8'hFF, 8'h5A},
    {1'b0, 8'h02, 8'h00, 8'h03},
    {1'b1, 8'h00, 8'hC3, 8'hC3}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b1;
  logic       scl_i = 1'b1;
  logic       m_low = 1'b0;
  logic [7:0] status_i = 8'h00;
  logic       sda_oe_o;
  logic [7:0] user_led_o;
  logic       sda_i;

  int  n_chk = 0;
  int  n_fail = 0;
  int  viol_r12 = 0;
  bit  done = 0;
  bit  oe_seen = 0;
  logic prev_oe = 1'b0;

  assign sda_i = ~(m_low | sda_oe_o);

  always #2 clk = ~clk;

  i2c_regfile_target dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .sda_oe_o   (sda_oe_o),
    .status_i   (status_i),
    .user_led_o (user_led_o)
  );

  always @(negedge clk) begin
    if (rst_n && sda_oe_o !== prev_oe && scl_i) viol_r12++;
    if (sda_oe_o) oe_seen = 1'b1;
    prev_oe = sda_oe_o;
  end

  task automatic qwait();
    repeat (Q) @(negedge clk);
  endtask

  task automatic check8(input string tag, input string what,
                        input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic i2c_start();
    m_low = 1'b0; qwait();
    scl_i = 1'b1; qwait();
    m_low = 1'b1; qwait();
    scl_i = 1'b0; qwait();
  endtask

  task automatic i2c_stop();
    m_low = 1'b1; qwait();
    scl_i = 1'b1; qwait();
    m_low = 1'b0; qwait();
  endtask

  task automatic send_bits(input logic [7:0] b, input int nb);
    for (int i = 7; i > 7 - nb; i--) begin
      m_low = ~b[i]; qwait();
      scl_i = 1'b1; qwait(); qwait();
      scl_i = 1'b0; qwait();
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    send_bits(b, 8);
    m_low = 1'b0; qwait();
    scl_i = 1'b1; qwait();
    ack = (sda_i == 1'b0);
    qwait();
    scl_i = 1'b0; qwait();
  endtask

  task automatic recv_byte(output logic [7:0] b, input bit give_ack);
    m_low = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      qwait();
      scl_i = 1'b1; qwait();
      b[i] = sda_i;
      qwait();
      scl_i = 1'b0;
    end
    qwait();
    m_low = give_ack; qwait();
    scl_i = 1'b1; qwait(); qwait();
    scl_i = 1'b0; qwait();
    m_low = 1'b0;
  endtask

  task automatic write_reg(input logic [7:0] idx, input logic [7:0] data, output bit all_ack);
    bit a0, a1, a2;
    i2c_start();
    send_byte({TGT, 1'b0}, a0);
    send_byte(idx, a1);
    send_byte(data, a2);
    i2c_stop();
    all_ack = a0 & a1 & a2;
  endtask

  task automatic read_reg(input logic [7:0] idx, output logic [7:0] val);
    bit a;
    i2c_start();
    send_byte({TGT, 1'b0}, a);
    send_byte(idx, a);
    i2c_start();
    send_byte({TGT, 1'b1}, a);
    recv_byte(val, 1'b0);
    i2c_stop();
  endtask

  function automatic string tag_of(input logic wr, input logic [7:0] idx);
    if (wr) return (idx == 8'h00) ? "R5" : "R8";
    if (idx == 8'h00) return "R5";
    if (idx <= 8'h03) return "R6";
    if (idx == 8'h04) return "R7";
    return "R9";
  endfunction

  initial begin : main
    logic [7:0] rd;
    logic [24:0] v;
    bit a, b, allk;
    #1 rst_n = 1'b0;
    repeat (4) @(negedge clk);
    check8("R1", "LED after reset", user_led_o, 8'h01);
    check8("R1", "SDA enable after reset", {7'd0, sda_oe_o}, 8'h00);
    rst_n = 1'b1;
    qwait();

    // R3: foreign address, then bytes that would hit the LED register
    oe_seen = 1'b0;
    i2c_start();
    send_byte({7'h31, 1'b0}, a);
    check8("R3", "ack for address 0x31", {7'd0, a}, 8'h00);
    send_byte(8'h00, a);
    send_byte(8'hAA, b);
    i2c_stop();
    check8("R3", "SDA driven during foreign transaction", {7'd0, oe_seen}, 8'h00);
    check8("R3", "LED after foreign write", user_led_o, 8'h01);

    // R2: own address acknowledged for write and read
    i2c_start();
    send_byte({TGT, 1'b0}, a);
    check8("R2", "ack for write address", {7'd0, a}, 8'h01);
    send_byte(8'h01, a);
    i2c_start();
    send_byte({TGT, 1'b1}, a);
    check8("R2", "ack for read address", {7'd0, a}, 8'h01);
    recv_byte(rd, 1'b0);
    qwait();
    check8("R10", "SDA enable after NACK", {7'd0, sda_oe_o}, 8'h00);
    i2c_stop();

    // table walk
    status_i = 8'h5C;
    for (int i = 0; i < NV; i++) begin
      v = VEC[i];
      if (v[24]) begin
        write_reg(v[23:16], v[15:8], allk);
        check8(tag_of(1'b1, v[23:16]), "all bytes acknowledged", {7'd0, allk}, 8'h01);
        check8(tag_of(1'b1, v[23:16]), "LED after write", user_led_o, v[7:0]);
      end else begin
        read_reg(v[23:16], rd);
        check8(tag_of(1'b0, v[23:16]), "read value", rd, v[7:0]);
      end
    end

    // R4: sequential read from index 0 with master ACKs
    i2c_start();
    send_byte({TGT, 1'b0}, a);
    send_byte(8'h00, a);
    i2c_start();
    send_byte({TGT, 1'b1}, a);
    recv_byte(rd, 1'b1); check8("R4", "burst byte 0", rd, 8'hC3);
    recv_byte(rd, 1'b1); check8("R4", "burst byte 1", rd, 8'h01);
    recv_byte(rd, 1'b1); check8("R4", "burst byte 2", rd, 8'h03);
    recv_byte(rd, 1'b1); check8("R4", "burst byte 3", rd, 8'h03);
    recv_byte(rd, 1'b0); check8("R4", "burst byte 4", rd, 8'h5C);
    i2c_stop();

    // R4 and R8: multi-byte write, only the first data byte lands in the LED
    i2c_start();
    send_byte({TGT, 1'b0}, a);
    send_byte(8'h00, a);
    send_byte(8'h11, a);
    send_byte(8'h22, a);
    send_byte(8'h33, b);
    i2c_stop();
    check8("R8", "ack on read-only write", {7'd0, b}, 8'h01);
    check8("R4", "LED after burst write", user_led_o, 8'h11);
    read_reg(8'h01, rd);
    check8("R8", "boot variant after write", rd, 8'h01);

    // R7: live status snapshot
    status_i = 8'h10;
    read_reg(8'h04, rd);
    check8("R7", "status with RTC interrupt", rd, 8'h10);
    status_i = 8'hEF;
    read_reg(8'h04, rd);
    check8("R7", "status without RTC interrupt", rd, 8'hEF);

    // R11: STOP inside a byte, then a normal read
    i2c_start();
    send_byte({TGT, 1'b0}, a);
    send_bits(8'hA5, 4);
    i2c_stop();
    read_reg(8'h00, rd);
    check8("R11", "read after mid-byte STOP", rd, 8'h11);

    // R11: repeated START inside the index byte keeps the index
    i2c_start();
    send_byte({TGT, 1'b0}, a);
    send_bits(8'hFF, 3);
    i2c_start();
    send_byte({TGT, 1'b1}, a);
    check8("R11", "ack after mid-byte START", {7'd0, a}, 8'h01);
    recv_byte(rd, 1'b0);
    i2c_stop();
    check8("R11", "read after mid-byte START", rd, 8'h01);

    n_chk++;
    if (viol_r12 != 0) begin
      n_fail++;
      $display("FAIL R12 SDA enable changed with SCL high: actual %0d expected 0", viol_r12);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : watchdog
    repeat (WD) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual cycles %0d expected fewer", WD);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule